// File: doc/BRIEF.md
# Byte-Lane SRAM Device Model with Dual Chip Select

A clocked, synthesizable stand-in for an asynchronous 16-bit static RAM. A memory controller under test drives it in simulation. On every rising clock edge the model samples its pin-level inputs:

- the word address;
- an active-low chip select and an active-high chip select;
- the write strobe;
- the output enable;
- the two byte-lane enables;
- the write data.

It then applies the device's mode table. The model cannot drive tristate pins, so it reports for each lane whether that lane would drive. An undriven lane reads as zero.

The array depth is set by a parameter, so a simulation can use a small memory. On reset the array is loaded with an address-derived pattern, so reads of locations that were never written give known values. A protocol-error output pulses when the controller moves the address while a write is still held, which is a breach of the address-valid-to-end-of-write rule.

Top module: `bls_sram_top`

## Requirements
- R1: The device is deselected when `cs_a_n_i` is 1 or `cs_b_i` is 0. While deselected, neither lane drives and nothing is written, whatever the address, data, strobe, output-enable and lane-enable inputs are.
- R2: When the device is selected with both `lane_hi_n_i` and `lane_lo_n_i` at 1, neither lane drives and nothing is written.
- R3: When the device is selected with `wr_n_i` at 0, every lane whose enable is 0 stores its byte of `wdata_i` at `addr_i`. `oe_n_i` has no effect, and no lane drives in the following cycle.
- R4: When the device is selected with `wr_n_i` at 1 and `oe_n_i` at 0, every enabled lane drives its stored byte and every disabled lane does not drive.
- R5: When the device is selected with both `wr_n_i` and `oe_n_i` at 1, neither lane drives.
- R6: The low lane covers data bits 7:0 and is enabled by `lane_lo_n_i`. The high lane covers bits 15:8 and is enabled by `lane_hi_n_i`. Writing one lane leaves the other lane's stored byte unchanged.
- R7: After reset, the word at address a holds a[7:0] XOR 8'h5A in bits 15:8 and the bitwise inverse of a[7:0] in bits 7:0.
- R8: `proto_err_o` is 1 for the cycle after a sample that meets all of these conditions: the device is selected with `wr_n_i` at 0, the previous sample was also selected with `wr_n_i` at 0, and the address differs from that previous sample. In every other cycle it is 0.
- R9: `rdata_o`, `drv_lo_o` and `drv_hi_o` reflect the inputs sampled at the previous rising edge. A lane that does not drive reads as zero on `rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address |
| cs_a_n_i | input | 1 | Chip select, active low |
| cs_b_i | input | 1 | Chip select, active high |
| wr_n_i | input | 1 | Write strobe, active low |
| oe_n_i | input | 1 | Output enable, active low |
| lane_hi_n_i | input | 1 | High-byte lane enable, active low |
| lane_lo_n_i | input | 1 | Low-byte lane enable, active low |
| wdata_i | input | 2*LANE_W | Write data |
| rdata_o | output | 2*LANE_W | Read data; undriven lanes are zero |
| drv_lo_o | output | 1 | Low lane would drive the bus |
| drv_hi_o | output | 1 | High lane would drive the bus |
| proto_err_o | output | 1 | Address moved during a held write |

## Verification
A mode-decode fault appears within one cycle, either as a lane drive flag that is set or cleared wrongly or as write data landing while the device is deselected. A corrupted stored byte stays hidden until that word is read, so each write and each ignored-write scenario is followed at once by a read of the affected word, and lane-isolation faults are caught by reading the full word back. A guard register that holds a stale address or activity bit shows up as a missing or extra error pulse exactly one cycle after the second write sample.

// File: rtl/bls_pkg.sv
package bls_pkg;

  // Decoded per-cycle control for the two byte lanes (index 0 = low lane).
  typedef struct packed {
    logic       sel;     // device selected
    logic       wr_act;  // selected with write strobe low
    logic [1:0] wr_ln;   // lane write enables
    logic [1:0] rd_ln;   // lane drive enables
  } bls_ctl_t;

  localparam int unsigned LANES = 2;

endpackage

// File: rtl/bls_decode.sv
module bls_decode
  import bls_pkg::*;
(
  input  logic     cs_a_n,
  input  logic     cs_b,
  input  logic     wr_n,
  input  logic     oe_n,
  input  logic     hi_n,
  input  logic     lo_n,
  output bls_ctl_t ctl
);

  logic [1:0] lane_on;

  always_comb begin
    lane_on    = {~hi_n, ~lo_n};
    ctl        = '0;
    ctl.sel    = ~cs_a_n & cs_b;
    ctl.wr_act = ctl.sel & ~wr_n;
    if (ctl.sel) begin
      if (!wr_n) begin
        ctl.wr_ln = lane_on;            // strobe wins over output enable
      end else if (!oe_n) begin
        ctl.rd_ln = lane_on;
      end
    end
  end

  // R3: a lane is never written and driven in the same sample
  always_comb begin
    a_r3_no_rw_overlap: assert (!((|ctl.wr_ln) && (|ctl.rd_ln)));
  end

endmodule

// File: rtl/bls_array.sv
module bls_array
  import bls_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [2*LANE_W-1:0]   wdata,
  input  logic [LANES-1:0]      wr_ln,
  input  logic [LANES-1:0]      rd_ln,
  output logic [2*LANE_W-1:0]   rdata,
  output logic [LANES-1:0]      drv
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [2*LANE_W-1:0] rdata_d, rdata_q;
  logic [LANES-1:0]    drv_d, drv_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [LANE_W-1:0] MASK = (l == 0) ? {LANE_W{1'b1}} : LANE_W'(8'h5A);

    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) begin
          mem_q[i] <= LANE_W'(i) ^ MASK;
        end
      end else if (wr_ln[l]) begin
        mem_q[addr] <= wdata[l*LANE_W +: LANE_W];
      end
    end

    always_comb begin
      rdata_d[l*LANE_W +: LANE_W] = rd_ln[l] ? mem_q[addr] : '0;
      drv_d[l] = rd_ln[l];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      drv_q   <= '0;
    end else begin
      rdata_q <= rdata_d;
      drv_q   <= drv_d;
    end
  end

  assign rdata = rdata_q;
  assign drv   = drv_q;

  // R9: the output register follows the sampled drive enables one cycle later
  a_r9_drive_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> drv == $past(rd_ln));

endmodule

// File: rtl/bls_wrguard.sv
module bls_wrguard #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_act,
  input  logic [ADDR_W-1:0] addr,
  output logic              err
);

  logic              prev_act_d, prev_act_q;
  logic [ADDR_W-1:0] prev_addr_d, prev_addr_q;
  logic              err_d, err_q;

  always_comb begin
    prev_act_d  = wr_act;
    prev_addr_d = wr_act ? addr : prev_addr_q;
    err_d       = wr_act & prev_act_q & (addr != prev_addr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_act_q  <= 1'b0;
      prev_addr_q <= '0;
      err_q       <= 1'b0;
    end else begin
      prev_act_q  <= prev_act_d;
      prev_addr_q <= prev_addr_d;
      err_q       <= err_d;
    end
  end

  assign err = err_q;

  // R8: an error pulse is always caused by a held write in the prior sample
  a_r8_err_has_write: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(wr_act));

endmodule

// File: rtl/bls_sram_top.sv
module bls_sram_top
  import bls_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                cs_a_n_i,
  input  logic                cs_b_i,
  input  logic                wr_n_i,
  input  logic                oe_n_i,
  input  logic                lane_hi_n_i,
  input  logic                lane_lo_n_i,
  input  logic [2*LANE_W-1:0] wdata_i,
  output logic [2*LANE_W-1:0] rdata_o,
  output logic                drv_lo_o,
  output logic                drv_hi_o,
  output logic                proto_err_o
);

  bls_ctl_t   ctl;
  logic [1:0] drv;

  bls_decode u_dec (
    .cs_a_n (cs_a_n_i),
    .cs_b   (cs_b_i),
    .wr_n   (wr_n_i),
    .oe_n   (oe_n_i),
    .hi_n   (lane_hi_n_i),
    .lo_n   (lane_lo_n_i),
    .ctl    (ctl)
  );

  bls_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_arr (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr_i),
    .wdata (wdata_i),
    .wr_ln (ctl.wr_ln),
    .rd_ln (ctl.rd_ln),
    .rdata (rdata_o),
    .drv   (drv)
  );

  bls_wrguard #(.ADDR_W(ADDR_W)) u_grd (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_act (ctl.wr_act),
    .addr   (addr_i),
    .err    (proto_err_o)
  );

  assign drv_lo_o = drv[0];
  assign drv_hi_o = drv[1];

  a_r1_standby_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_a_n_i || !cs_b_i) |=> (!drv_lo_o && !drv_hi_o));

  a_r2_no_lane_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.sel && lane_hi_n_i && lane_lo_n_i) |=> (!drv_lo_o && !drv_hi_o));

  a_r3_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.sel && !wr_n_i) |=> (!drv_lo_o && !drv_hi_o));

  a_r4_read_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.sel && wr_n_i && !oe_n_i) |=> ({drv_hi_o, drv_lo_o} == $past({~lane_hi_n_i, ~lane_lo_n_i})));

  a_r5_idle_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.sel && wr_n_i && oe_n_i) |=> (!drv_lo_o && !drv_hi_o));

  a_r8_err_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err_o |-> $past(!cs_a_n_i && cs_b_i && !wr_n_i));

endmodule

// File: tb/bls_sram_top_tb_top.sv
module bls_sram_top_tb_top;

  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          cs_a_n, cs_b, wr_n, oe_n, hi_n, lo_n;
  logic [15:0]   wdata;
  logic [15:0]   rdata;
  logic          drv_lo, drv_hi, perr;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bls_sram_top #(.ADDR_W(AW), .LANE_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .cs_a_n_i(cs_a_n), .cs_b_i(cs_b),
    .wr_n_i(wr_n), .oe_n_i(oe_n), .lane_hi_n_i(hi_n), .lane_lo_n_i(lo_n),
    .wdata_i(wdata), .rdata_o(rdata), .drv_lo_o(drv_lo), .drv_hi_o(drv_hi),
    .proto_err_o(perr)
  );

  function automatic logic [15:0] init_word(input int a);
    logic [7:0] b = 8'(a);
    return {b ^ 8'h5A, ~b};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drive one sample (called just after a falling edge); returns at the next falling edge.
  task automatic cyc(input logic a_n, input logic b, input logic w_n, input logic o_n,
                     input logic h_n, input logic l_n, input int a, input logic [15:0] d);
    cs_a_n = a_n; cs_b = b; wr_n = w_n; oe_n = o_n; hi_n = h_n; lo_n = l_n;
    addr = AW'(a); wdata = d;
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(1, 0, 1, 1, 1, 1, 0, 16'h0);
  endtask

  task automatic wr(input int a, input logic h_n, input logic l_n, input logic [15:0] d);
    cyc(0, 1, 0, 1, h_n, l_n, a, d);
  endtask

  task automatic rd_chk(input string req, input int a, input logic h_n, input logic l_n,
                        input logic [15:0] exp);
    cyc(0, 1, 1, 0, h_n, l_n, a, 16'hDEAD);
    chk(req, {14'b0, drv_hi, drv_lo}, {30'b0, ~h_n, ~l_n});
    chk(req, rdata, exp);
  endtask

  task automatic t_reset();
    chk("R9 reset outputs", {rdata, drv_hi, drv_lo, perr}, 19'h0);
    rd_chk("R7 init a5", 5, 0, 0, init_word(5));
    rd_chk("R7 init a63", 63, 0, 0, init_word(63));
    rd_chk("R7 init a0", 0, 0, 0, init_word(0));
    idle();
  endtask

  task automatic t_lanes();
    wr(3, 0, 0, 16'h1234);
    chk("R3 no drive during write", {drv_hi, drv_lo}, 2'b00);
    idle();
    rd_chk("R3 full write", 3, 0, 0, 16'h1234);
    wr(3, 1, 0, 16'hFFAB);
    idle();
    rd_chk("R6 low lane only", 3, 0, 0, 16'h12AB);
    wr(3, 0, 1, 16'hCD77);
    idle();
    rd_chk("R6 high lane only", 3, 0, 0, 16'hCDAB);
    rd_chk("R4 low lane drive", 3, 1, 0, 16'h00AB);
    rd_chk("R4 high lane drive", 3, 0, 1, 16'hCD00);
    idle();
  endtask

  task automatic t_oe_during_write();
    cyc(0, 1, 0, 0, 0, 0, 7, 16'h7777);
    chk("R3 OE ignored during write", {drv_hi, drv_lo}, 2'b00);
    idle();
    rd_chk("R3 write with OE low stored", 7, 0, 0, 16'h7777);
    idle();
  endtask

  task automatic t_standby();
    cyc(1, 1, 0, 0, 0, 0, 9, 16'h0000);
    chk("R1 CE-low-active high: no drive", {drv_hi, drv_lo}, 2'b00);
    cyc(0, 0, 0, 0, 0, 0, 9, 16'h0000);
    chk("R1 CE-high-active low: no drive", {drv_hi, drv_lo}, 2'b00);
    cyc(1, 1, 1, 0, 0, 0, 9, 16'h0000);
    chk("R1 standby read blocked", {rdata, drv_hi, drv_lo}, 18'h0);
    rd_chk("R1 standby write ignored", 9, 0, 0, init_word(9));
    idle();
  endtask

  task automatic t_no_lane();
    wr(10, 1, 1, 16'h0000);
    cyc(0, 1, 1, 0, 1, 1, 10, 16'h0);
    chk("R2 no lane: no drive", {rdata, drv_hi, drv_lo}, 18'h0);
    rd_chk("R2 no lane write ignored", 10, 0, 0, init_word(10));
    idle();
  endtask

  task automatic t_idle();
    cyc(0, 1, 1, 1, 0, 0, 3, 16'h0);
    chk("R5 WE and OE high: no drive", {rdata, drv_hi, drv_lo}, 18'h0);
    idle();
  endtask

  task automatic t_err();
    wr(12, 0, 0, 16'h1111);
    chk("R8 first write no error", perr, 0);
    wr(13, 0, 0, 16'h2222);
    chk("R8 address moved during write", perr, 1);
    idle();
    chk("R8 pulse ends", perr, 0);
    wr(14, 0, 0, 16'h3333);
    wr(14, 0, 0, 16'h3333);
    chk("R8 same address no error", perr, 0);
    idle();
    wr(15, 0, 0, 16'h4444);
    cyc(1, 1, 0, 1, 0, 0, 16, 16'h0);
    wr(17, 0, 0, 16'h5555);
    chk("R8 standby breaks held write", perr, 0);
    idle();
    chk("R8 quiet after", perr, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    cs_a_n = 1; cs_b = 0; wr_n = 1; oe_n = 1; hi_n = 1; lo_n = 1;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lanes();
    t_oe_during_write();
    t_standby();
    t_no_lane();
    t_idle();
    t_err();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule